// File: doc/BRIEF.md
# Virtual-Channel Link Packet Transmitter

This block places packets from three virtual-channel queues onto one unidirectional point-to-point link. The queues carry posted requests (no reply expected), non-posted requests (a reply is expected) and responses (answers to non-posted requests). Each queue offers one packet descriptor at a time. A descriptor holds a control packet of one or two 32-bit words and a payload length counted in 32-bit words. The transmitter reads payload words through an indexed read port, so the payload storage stays outside the block. It emits one 32-bit word per accepted cycle, with a flag that tells control words apart from data words.

The three queues are served round-robin, one whole packet at a time. A separate urgent port carries 8-byte high-priority commands. At a packet boundary an urgent command goes ahead of all queues. While a payload is streaming, an urgent command can be slipped in after any payload word except the last, and the payload then resumes at the next word. Only one urgent command is in flight at a time, and at least one payload word separates two insertions into the same payload.

Top module: `vct_link_tx`

## Requirements
- R1: After reset `lnk_valid`, `pkt_ready` and `urg_ready` are low, `rd_ch` and `rd_idx` are zero, and the first queue served is channel 0.
- R2: A control packet is sent as `pkt_ctl` word `[31:0]` of the channel, followed by word `[63:32]` only when `pkt_ctl_long` is set. `lnk_is_ctl` is high on these words.
- R3: Right after its control words, a packet sends exactly `pkt_dlen` payload words (0 to 16; 0 means no payload). These are `rd_data` read at `rd_idx` = 0, 1, ... in order, with `lnk_is_ctl` low.
- R4: Queues with pending packets are granted in rotating order: channel 0, 1, 2, 0, ... one packet per grant.
- R5: A channel whose `pkt_valid` is low is skipped, and its turn passes to the next pending channel.
- R6: While `lnk_valid` is high and `lnk_ready` is low, the word, the flag and the read address are held, and nothing is skipped or repeated.
- R7: When `urg_valid` is high as a payload word that is not the last one is accepted, the next two words are `urg_ctl[31:0]` and then `urg_ctl[63:32]` (flag high). The payload then resumes at the following index.
- R8: Only one urgent command is sent at a time. After an insertion, at least one payload word is sent before another insertion into the same payload.
- R9: At a packet boundary a pending urgent command is sent before any queue packet. A command that is pending as the last payload word is accepted is not inserted, and follows the packet instead.
- R10: `pkt_ready[c]` pulses for exactly one cycle, on the cycle the last word of channel c's packet is accepted.
- R11: `urg_ready` pulses on the cycle the second word of an urgent command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 3 | Per channel: descriptor present (0 posted, 1 non-posted, 2 response) |
| pkt_ctl_long | input | 3 | Per channel: control packet is 8 bytes |
| pkt_ctl | input | 192 | Per channel 64-bit control packet, channel c at bits [64c+63:64c] |
| pkt_dlen | input | 15 | Per channel payload length in words, channel c at bits [5c+4:5c] |
| pkt_ready | output | 3 | Per channel pop pulse, descriptor consumed |
| rd_ch | output | 2 | Channel whose payload is being read |
| rd_idx | output | 4 | Payload word index being read |
| rd_data | input | 32 | Payload word at (`rd_ch`, `rd_idx`), combinational |
| urg_valid | input | 1 | Urgent command pending |
| urg_ctl | input | 64 | Urgent 8-byte command |
| urg_ready | output | 1 | Urgent command consumed |
| lnk_valid | output | 1 | Link word valid |
| lnk_ready | input | 1 | Link accepts word |
| lnk_word | output | 32 | Link word |
| lnk_is_ctl | output | 1 | High for control words, low for payload words |

## Verification
Every link word is presented combinationally from the sequencer state. A word accepted on one clock edge is therefore followed at the next edge by its successor, and a one-cycle gap with `lnk_valid` low sits between packets. The pop and urgent-done pulses fall on the same edge as the accepted last word. The decision to insert is taken at the edge that accepts a payload word, so the inserted words begin in the very next cycle. The bench samples every output at the falling edge, scores each accepted word against an arithmetically built expected stream, and raises urgent commands at the falling edge just before the chosen payload word is accepted. Because of this, the insertion point does not depend on the pseudo-random stalls applied to `lnk_ready`.

// File: rtl/vct_pkg.sv
// Shared types of the virtual-channel link transmitter.
package vct_pkg;
    // Sequencer phase: nothing on the link, control words, payload words,
    // urgent command words.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CTL  = 2'd1,
        PH_DATA = 2'd2,
        PH_URG  = 2'd3
    } vct_phase_e;
endpackage

// File: rtl/vct_rr_arb.sv
// Round-robin channel picker.
// Looks for the first requesting channel after the last granted one. The
// pointer starts at the highest channel, so channel 0 wins first after reset.
// Assumes take is asserted only when any is high.
module vct_rr_arb #(
    parameter int N_CH = 3,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] req,
    input  logic            take,
    output logic [CHW-1:0]  gnt,
    output logic            any
);
    logic [CHW-1:0] last_q;

    // Scan offsets from far to near so the nearest requester wins.
    always_comb begin
        any = 1'b0;
        gnt = last_q;
        for (int k = N_CH; k >= 1; k--) begin
            if (req[(int'(last_q) + k) % N_CH]) begin
                any = 1'b1;
                gnt = CHW'((int'(last_q) + k) % N_CH);
            end
        end
    end

    // Remember the channel that took the last grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= CHW'(N_CH - 1);
        else if (take)
            last_q <= gnt;
    end
endmodule

// File: rtl/vct_seq.sv
// Packet sequencer.
// Steps through control words, payload words and inserted urgent words,
// one step per accepted link word. An urgent command is taken at a packet
// boundary, or right after a payload word that is not the last one.
// Assumes the current channel's descriptor stays stable until it is popped.
module vct_seq
    import vct_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int MAXW = 16,
    localparam int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int DLW  = $clog2(MAXW + 1),
    localparam int IDXW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc,
    input  logic            urg_valid,
    input  logic            any,
    input  logic [CHW-1:0]  gnt,
    input  logic            cur_long,
    input  logic [DLW-1:0]  cur_dlen,
    output vct_phase_e      ph,
    output logic [CHW-1:0]  cur_ch,
    output logic            cidx,
    output logic [IDXW-1:0] didx,
    output logic            uidx,
    output logic            take,
    output logic            pop,
    output logic            urg_done
);
    logic ret_data;
    logic ctl_end;
    logic data_end;

    // Decode the end of the control part and of the payload.
    always_comb begin
        ctl_end  = (cidx == cur_long);
        data_end = (DLW'(didx) == cur_dlen - DLW'(1));
        take     = (ph == PH_IDLE) && !urg_valid && any;
        pop      = acc && (((ph == PH_CTL) && ctl_end && (cur_dlen == '0)) ||
                           ((ph == PH_DATA) && data_end));
        urg_done = acc && (ph == PH_URG) && uidx;
    end

    // Phase and pointer update, one step per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cur_ch   <= '0;
            cidx     <= 1'b0;
            didx     <= '0;
            uidx     <= 1'b0;
            ret_data <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (urg_valid) begin
                        ph       <= PH_URG;
                        uidx     <= 1'b0;
                        ret_data <= 1'b0;
                    end else if (any) begin
                        ph     <= PH_CTL;
                        cur_ch <= gnt;
                        cidx   <= 1'b0;
                    end
                end
                PH_CTL: begin
                    if (acc) begin
                        if (!ctl_end) begin
                            cidx <= 1'b1;
                        end else if (cur_dlen == '0) begin
                            ph <= PH_IDLE;
                        end else begin
                            ph   <= PH_DATA;
                            didx <= '0;
                        end
                    end
                end
                PH_DATA: begin
                    if (acc) begin
                        if (data_end) begin
                            ph <= PH_IDLE;
                        end else begin
                            didx <= didx + IDXW'(1);
                            if (urg_valid) begin
                                ph       <= PH_URG;
                                uidx     <= 1'b0;
                                ret_data <= 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    if (acc) begin
                        if (uidx)
                            ph <= ret_data ? PH_DATA : PH_IDLE;
                        else
                            uidx <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vct_word_mux.sv
// Link word selector.
// Picks the word to show on the link from the sequencer phase: a control
// word of the current channel, the payload read data, or an urgent word.
// Purely combinational.
module vct_word_mux
    import vct_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int WW   = 32,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  vct_phase_e           ph,
    input  logic [CHW-1:0]       cur_ch,
    input  logic                 cidx,
    input  logic                 uidx,
    input  logic [N_CH*2*WW-1:0] pkt_ctl,
    input  logic [WW-1:0]        rd_data,
    input  logic [2*WW-1:0]      urg_ctl,
    output logic [WW-1:0]        word,
    output logic                 is_ctl
);
    // Select the word by phase; the flag marks control phases.
    always_comb begin
        word   = '0;
        is_ctl = 1'b0;
        case (ph)
            PH_CTL: begin
                word   = pkt_ctl[(int'(cur_ch) * 2 + int'(cidx)) * WW +: WW];
                is_ctl = 1'b1;
            end
            PH_DATA: word = rd_data;
            PH_URG: begin
                word   = urg_ctl[int'(uidx) * WW +: WW];
                is_ctl = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vct_link_tx.sv
// Virtual-channel link packet transmitter (top).
// Serves three packet queues round-robin and serialises each packet onto a
// 32-bit valid/ready link. Urgent 8-byte commands can be inserted into a
// running payload. Assumes descriptors and urgent commands are held stable
// until popped, and rd_data is a combinational function of rd_ch/rd_idx.
module vct_link_tx
    import vct_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int WW   = 32,
    parameter int MAXW = 16,
    localparam int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int DLW  = $clog2(MAXW + 1),
    localparam int IDXW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH-1:0]      pkt_valid,
    input  logic [N_CH-1:0]      pkt_ctl_long,
    input  logic [N_CH*2*WW-1:0] pkt_ctl,
    input  logic [N_CH*DLW-1:0]  pkt_dlen,
    output logic [N_CH-1:0]      pkt_ready,
    output logic [CHW-1:0]       rd_ch,
    output logic [IDXW-1:0]      rd_idx,
    input  logic [WW-1:0]        rd_data,
    input  logic                 urg_valid,
    input  logic [2*WW-1:0]      urg_ctl,
    output logic                 urg_ready,
    output logic                 lnk_valid,
    input  logic                 lnk_ready,
    output logic [WW-1:0]        lnk_word,
    output logic                 lnk_is_ctl
);
    vct_phase_e      ph;
    logic [CHW-1:0]  cur_ch;
    logic            cidx;
    logic            uidx;
    logic [IDXW-1:0] didx;
    logic [CHW-1:0]  gnt;
    logic            any;
    logic            take;
    logic            pop;
    logic            acc;
    logic            cur_long;
    logic [DLW-1:0]  cur_dlen;

    // Handshake and current-descriptor fields.
    always_comb begin
        lnk_valid = (ph != PH_IDLE);
        acc       = lnk_valid && lnk_ready;
        cur_long  = pkt_ctl_long[cur_ch];
        cur_dlen  = pkt_dlen[int'(cur_ch) * DLW +: DLW];
        rd_ch     = cur_ch;
        rd_idx    = didx;
    end

    // Steer the pop pulse to the channel being served.
    always_comb begin
        for (int c = 0; c < N_CH; c++)
            pkt_ready[c] = pop && (int'(cur_ch) == c);
    end

    vct_rr_arb #(.N_CH(N_CH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pkt_valid),
        .take  (take),
        .gnt   (gnt),
        .any   (any)
    );

    vct_seq #(.N_CH(N_CH), .MAXW(MAXW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .urg_valid (urg_valid),
        .any       (any),
        .gnt       (gnt),
        .cur_long  (cur_long),
        .cur_dlen  (cur_dlen),
        .ph        (ph),
        .cur_ch    (cur_ch),
        .cidx      (cidx),
        .didx      (didx),
        .uidx      (uidx),
        .take      (take),
        .pop       (pop),
        .urg_done  (urg_ready)
    );

    vct_word_mux #(.N_CH(N_CH), .WW(WW)) u_mux (
        .ph      (ph),
        .cur_ch  (cur_ch),
        .cidx    (cidx),
        .uidx    (uidx),
        .pkt_ctl (pkt_ctl),
        .rd_data (rd_data),
        .urg_ctl (urg_ctl),
        .word    (lnk_word),
        .is_ctl  (lnk_is_ctl)
    );
endmodule

// File: rtl/vct_link_tx_chk.sv
// Property checker for the link transmitter, bound to every instance.
module vct_link_tx_chk #(
    parameter int N_CH = 3,
    parameter int WW   = 32,
    parameter int CHW  = 2,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] pkt_ready,
    input logic [CHW-1:0]  rd_ch,
    input logic [IDXW-1:0] rd_idx,
    input logic            urg_ready,
    input logic            lnk_valid,
    input logic            lnk_ready,
    input logic [WW-1:0]   lnk_word,
    input logic            lnk_is_ctl
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lnk_valid && (pkt_ready == '0) && !urg_ready);

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_valid && !lnk_ready |=> lnk_valid && $stable(lnk_word) &&
        $stable(lnk_is_ctl) && $stable(rd_ch) && $stable(rd_idx));

    // R10
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pkt_ready));

    // R10
    pop_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready != '0) |-> lnk_valid && lnk_ready);

    // R11
    urg_done_on_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urg_ready |-> lnk_valid && lnk_ready && lnk_is_ctl);

    // R8
    urg_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urg_ready |=> !urg_ready);
endmodule

bind vct_link_tx vct_link_tx_chk #(
    .N_CH (N_CH),
    .WW   (WW),
    .CHW  (CHW),
    .IDXW (IDXW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_ready  (pkt_ready),
    .rd_ch      (rd_ch),
    .rd_idx     (rd_idx),
    .urg_ready  (urg_ready),
    .lnk_valid  (lnk_valid),
    .lnk_ready  (lnk_ready),
    .lnk_word   (lnk_word),
    .lnk_is_ctl (lnk_is_ctl)
);

// File: tb/sim_vct_link_tx.sv
`timescale 1ns/1ps
module sim_vct_link_tx;
    localparam int N = 3;
    localparam int DLW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [N-1:0]      pkt_valid, pkt_ctl_long, pkt_ready;
    logic [N*64-1:0]   pkt_ctl;
    logic [N*DLW-1:0]  pkt_dlen;
    logic [1:0]        rd_ch;
    logic [3:0]        rd_idx;
    logic [31:0]       rd_data;
    logic              urg_valid, urg_ready;
    logic [63:0]       urg_ctl;
    logic              lnk_valid, lnk_ready, lnk_is_ctl;
    logic [31:0]       lnk_word;

    int q_n[N];
    int q_head[N];
    int q_dlen[N][0:63];
    bit q_long[N][0:63];
    int urg_issued, urg_done_cnt;
    logic [31:0] exp_w[0:2047];
    bit exp_c[0:2047];
    int exp_n, rx_n;
    int checks, fails, cyc;
    string cur_req;
    bit arm_on;
    int arm_k, arm_cnt;
    bit stall_en;
    logic [7:0] lfsr = 8'h5B;

    vct_link_tx u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ctl_long(pkt_ctl_long),
        .pkt_ctl(pkt_ctl), .pkt_dlen(pkt_dlen), .pkt_ready(pkt_ready),
        .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data),
        .urg_valid(urg_valid), .urg_ctl(urg_ctl), .urg_ready(urg_ready),
        .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_word(lnk_word),
        .lnk_is_ctl(lnk_is_ctl)
    );

    // Queue model: descriptors and payload words as arithmetic functions.
    always_comb begin
        for (int c = 0; c < N; c++) begin
            int h;
            h = (q_head[c] < 64) ? q_head[c] : 0;
            pkt_valid[c] = q_head[c] < q_n[c];
            pkt_ctl[c*64 +: 64] = {8'hC1, 8'(c), 16'(h), 8'hC0, 8'(c), 16'(h)};
            pkt_ctl_long[c] = q_long[c][h];
            pkt_dlen[c*DLW +: DLW] = DLW'(q_dlen[c][h]);
        end
        rd_data = {8'hDA, 6'd0, rd_ch, 8'(q_head[rd_ch]), 4'd0, rd_idx};
        urg_valid = urg_done_cnt < urg_issued;
        urg_ctl = {8'hE1, 16'(urg_done_cnt), 8'h00, 8'hE0, 16'(urg_done_cnt), 8'h00};
    end

    // Pop descriptors and urgent commands on the design's pulses.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N; c++) q_head[c] <= 0;
            urg_done_cnt <= 0;
        end else begin
            for (int c = 0; c < N; c++) if (pkt_ready[c]) q_head[c] <= q_head[c] + 1;
            if (urg_ready) urg_done_cnt <= urg_done_cnt + 1;
        end
    end

    // Pseudo-random back-pressure, changed just after each rising edge.
    initial begin
        lnk_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            lnk_ready = stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, expv);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog %s act=%0d exp=%0d", cur_req, rx_n, exp_n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Link monitor: score each accepted word; raise urgent commands on cue.
    always @(negedge clk) begin
        if (rst_n && lnk_valid && lnk_ready) begin
            if (rx_n < exp_n)
                chk(lnk_word == exp_w[rx_n] && lnk_is_ctl == exp_c[rx_n],
                    "link word", {lnk_word[30:0], lnk_is_ctl}, {exp_w[rx_n][30:0], exp_c[rx_n]});
            else
                chk(1'b0, "extra link word", lnk_word, 32'h0);
            if (arm_on && !lnk_is_ctl && lnk_word[7:0] == 8'(arm_k)) begin
                urg_issued = urg_issued + arm_cnt;
                arm_on = 1'b0;
            end
            rx_n++;
        end
    end

    task automatic push(input logic [31:0] w, input bit c);
        exp_w[exp_n] = w;
        exp_c[exp_n] = c;
        exp_n++;
    endtask

    task automatic add_pkt(input int c, input int dl, input bit lg);
        q_dlen[c][q_n[c]] = dl;
        q_long[c][q_n[c]] = lg;
        q_n[c]++;
    endtask

    task automatic exp_ctl(input int c, input int h);
        push({8'hC0, 8'(c), 16'(h)}, 1'b1);
        if (q_long[c][h]) push({8'hC1, 8'(c), 16'(h)}, 1'b1);
    endtask

    task automatic exp_data(input int c, input int h, input int from, input int upto);
        for (int i = from; i <= upto; i++)
            push({8'hDA, 8'(c), 8'(h), 8'(i)}, 1'b0);
    endtask

    task automatic exp_pkt(input int c, input int h);
        exp_ctl(c, h);
        exp_data(c, h, 0, q_dlen[c][h] - 1);
    endtask

    task automatic exp_urg(input int u);
        push({8'hE0, 16'(u), 8'h00}, 1'b1);
        push({8'hE1, 16'(u), 8'h00}, 1'b1);
    endtask

    task automatic begin_test(input string req, input bit stall);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        cur_req = req;
        stall_en = stall;
        for (int c = 0; c < N; c++) q_n[c] = 0;
        exp_n = 0;
        rx_n = 0;
        urg_issued = 0;
        arm_on = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic run_test();
        int guard;
        bit busy;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        guard = 0;
        busy = 1'b1;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
            busy = (rx_n < exp_n) || lnk_valid || (urg_done_cnt < urg_issued);
            for (int c = 0; c < N; c++) if (q_head[c] < q_n[c]) busy = 1'b1;
        end
        repeat (4) @(negedge clk);
        chk(rx_n == exp_n, "word count", rx_n, exp_n);
        chk(!lnk_valid, "idle at end", {31'd0, lnk_valid}, 32'd0);
        chk(urg_done_cnt == urg_issued, "urgent pops R11", urg_done_cnt, urg_issued);
        for (int c = 0; c < N; c++)
            chk(q_head[c] == q_n[c], "descriptor pops R10", q_head[c], q_n[c]);
    endtask

    initial begin
        rst_n = 1'b0;
        checks = 0; fails = 0; cyc = 0;
        urg_issued = 0; exp_n = 0; rx_n = 0; arm_on = 1'b0; stall_en = 1'b0;
        for (int c = 0; c < N; c++) q_n[c] = 0;

        // R1: reset state with empty queues.
        begin_test("R1", 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!lnk_valid && pkt_ready == '0 && !urg_ready, "outputs idle R1",
                {lnk_valid, pkt_ready, urg_ready}, 32'd0);
            chk(rd_ch == 2'd0 && rd_idx == 4'd0, "pointers zero R1", {rd_ch, rd_idx}, 32'd0);
        end

        // R2 R3 R6 R10: every payload length with short and long control, per channel.
        for (int c = 0; c < N; c++) begin
            begin_test("R2/R3/R6/R10 sweep", 1'b1);
            for (int lg = 0; lg < 2; lg++)
                for (int d = 0; d <= 16; d++) add_pkt(c, d, lg[0]);
            for (int h = 0; h < q_n[c]; h++) exp_pkt(c, h);
            run_test();
        end

        // R4 R1: rotation starts at channel 0.
        begin_test("R4 rotation", 1'b1);
        for (int c = 0; c < N; c++)
            for (int h = 0; h < 3; h++) add_pkt(c, c + 1, h[0]);
        for (int h = 0; h < 3; h++)
            for (int c = 0; c < N; c++) exp_pkt(c, h);
        run_test();

        // R5: empty channel 1 is skipped.
        begin_test("R5 skip", 1'b0);
        add_pkt(0, 2, 1'b0); add_pkt(0, 1, 1'b1);
        add_pkt(2, 3, 1'b1); add_pkt(2, 0, 1'b0);
        exp_pkt(0, 0); exp_pkt(2, 0); exp_pkt(0, 1); exp_pkt(2, 1);
        run_test();

        // R7 R8: two urgents raised before payload word 2; second waits one word.
        begin_test("R7/R8 insert", 1'b1);
        add_pkt(1, 8, 1'b1);
        arm_on = 1'b1; arm_k = 2; arm_cnt = 2;
        exp_ctl(1, 0); exp_data(1, 0, 0, 2); exp_urg(0);
        exp_data(1, 0, 3, 3); exp_urg(1); exp_data(1, 0, 4, 7);
        run_test();

        // R7: insertion after the first payload word, no stalls.
        begin_test("R7 insert first", 1'b0);
        add_pkt(2, 2, 1'b0);
        arm_on = 1'b1; arm_k = 0; arm_cnt = 1;
        exp_ctl(2, 0); exp_data(2, 0, 0, 0); exp_urg(0); exp_data(2, 0, 1, 1);
        run_test();

        // R9: urgent pending at reset goes before a queued packet.
        begin_test("R9 boundary", 1'b1);
        add_pkt(0, 2, 1'b1);
        urg_issued = 1;
        exp_urg(0); exp_pkt(0, 0);
        run_test();

        // R9: urgent raised at the last payload word follows the packet,
        // ahead of the other pending channel.
        begin_test("R9 last word", 1'b1);
        add_pkt(0, 3, 1'b0); add_pkt(1, 1, 1'b0);
        arm_on = 1'b1; arm_k = 2; arm_cnt = 1;
        exp_pkt(0, 0); exp_urg(0); exp_pkt(1, 0);
        run_test();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule